// File: doc/BRIEF.md
# Debug DMA transaction sequencer

This block sits on the host side of a debug port. It turns one memory access request into the ordered set of 32-bit register scans that a debug DMA engine behind the port expects. A request carries an address, an access size (byte, halfword or word), a direction, write data, an item count and a set of persistent control bits. The sequencer selects the address, data or control register on a simple scan port, shifts a value and takes the captured value back. It waits for the remote engine to clear its start flag and checks the error flag in the closing control scan. It re-runs a failed item from the beginning a bounded number of times.

For sub-word sizes, write data is copied into every lane of the 32-bit word. Read data is taken from the lane that the low address bits select and returned right-justified. A request with a count above one becomes a burst. The items run one after another, the address steps by the item size, and the burst stops at the first item that fails. One write value fills every item of a write burst. Each successful item gives a one-cycle item strobe. The request then ends with a one-cycle done pulse that carries a status code.

Top module: `dbg_dma_seq`

## Requirements
- R1: A read item issues these scans in order: address register (select 0, the item address), control register with the start word, one or more control polls, data register (select 1), and a final control scan. Scan select codes are 0 address, 1 data and 2 control.
- R2: A write item issues these scans in order: address register, data register carrying the lane-replicated write value, control register with the start word, one or more control polls, and a final control scan.
- R3: Control words are built from the base bits, sampled when the request is accepted, with bits 7 to 11 and bit 17 cleared. The start word adds access-enable (bit 17), start (bit 11), size in bits [8:7] (00 byte, 01 halfword, 10 word) and, for reads only, bit 9. The poll word adds only access-enable. The final word is the cleaned base alone.
- R4: Polling repeats while the captured poll value has bit 11 set. The first capture with bit 11 clear ends polling.
- R5: If POLL_MAX polls in a row capture bit 11 set, the sequencer issues the final control scan and then ends the request with status 2 (timeout), without retrying.
- R6: If the final scan captures bit 10 set, the item is restarted from its address scan. After RETRY_MAX restarts the request ends with status 1 (bus error), so an item makes at most RETRY_MAX+1 attempts.
- R7: Read data is returned right-justified. A halfword read takes bits [31:16] when address bit 1 is set and bits [15:0] otherwise. A byte read takes byte lane addr[1:0]. A word read returns the whole captured word.
- R8: A halfword write sends the value in both 16-bit halves. A byte write sends it in all four byte lanes.
- R9: A request with count N (0 acts as 1) runs N items at addresses that step by 1, 2 or 4 bytes. It strobes item_valid with item_rdata once per successful item, and ends with status 0.
- R10: A burst ends at the first item that exhausts its retries. No address scan for a later item is issued.
- R11: After reset req_ready is 1, scan_req is 0 and done is 0. A request is accepted only while req_ready is 1. done is high for exactly one cycle per request, and done_rdata holds the last read item.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request taken this cycle if valid |
| req_addr | input | 32 | Byte address of the first item |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | 32 | Write value, right-justified |
| req_count | input | CNT_W | Number of items, 0 treated as 1 |
| base_bits | input | 32 | Persistent control bits |
| scan_req | output | 1 | Scan requested, held until acknowledged |
| scan_sel | output | 2 | Register select: 0 address, 1 data, 2 control |
| scan_dout | output | 32 | Value shifted in |
| scan_ack | input | 1 | Scan finished, capture valid this cycle |
| scan_din | input | 32 | Captured value |
| item_valid | output | 1 | One-cycle strobe per successful item |
| item_rdata | output | 32 | Right-justified read data of that item |
| done | output | 1 | One-cycle end-of-request pulse |
| done_status | output | 2 | 0 ok, 1 bus error, 2 timeout |
| done_rdata | output | 32 | Read data of the last item, 0 on failure |

## Verification
A wrong phase register shows up at the scan port straight away. The next scan carries the wrong select or the wrong control word, and the captured log differs from the expected order within one scan. Off-by-one errors in the poll, retry or item counters show as extra or missing control or address scans, or as a wrong status on the done pulse of that request. Lane faults appear as a wrong data-register word on the next write, or as a wrong item_rdata on the strobe of the next sub-word read.

// File: rtl/dbg_dma_pkg.sv
// Shared definitions for the debug DMA sequencer: control-word bit
// positions, scan register selects, status codes and sequencer phases.
package dbg_dma_pkg;

    localparam int WORD_W    = 32;
    localparam int SZ_LSB    = 7;
    localparam int RD_BIT    = 9;
    localparam int ERR_BIT   = 10;
    localparam int START_BIT = 11;
    localparam int ACC_BIT   = 17;

    // Bits the sequencer owns; they are stripped from the base bits.
    localparam logic [WORD_W-1:0] OWNED_MASK =
        (32'h3 << SZ_LSB) | (32'h1 << RD_BIT) | (32'h1 << ERR_BIT) |
        (32'h1 << START_BIT) | (32'h1 << ACC_BIT);

    localparam logic [1:0] SEL_ADDR = 2'd0;
    localparam logic [1:0] SEL_DATA = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    localparam logic [1:0] ST_OK      = 2'd0;
    localparam logic [1:0] ST_BUSERR  = 2'd1;
    localparam logic [1:0] ST_TIMEOUT = 2'd2;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_WDATA,
        PH_START,
        PH_POLL,
        PH_RDATA,
        PH_FINAL
    } phase_e;

endpackage

// File: rtl/dbg_dma_lanes.sv
// Byte-lane unit. Replicates a right-justified write value across the
// lanes of a word, and extracts a right-justified value from a captured
// word by size and address offset. Purely combinational; assumes the
// offset is aligned to the size.
module dbg_dma_lanes
    import dbg_dma_pkg::*;
(
    input  logic [WORD_W-1:0] wr_value,
    input  logic [1:0]        wr_size,
    output logic [WORD_W-1:0] wr_lanes,
    input  logic [WORD_W-1:0] rd_word,
    input  logic [1:0]        rd_size,
    input  logic [1:0]        rd_off,
    output logic [WORD_W-1:0] rd_value
);
    localparam int NLANE = WORD_W / 8;

    logic [7:0] lane [NLANE];

    // Split the captured word into byte lanes.
    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        assign lane[g] = rd_word[8*g +: 8];
    end

    // Copy the write value into every lane of its size.
    always_comb begin
        case (wr_size)
            SZ_BYTE: wr_lanes = {NLANE{wr_value[7:0]}};
            SZ_HALF: wr_lanes = {(NLANE/2){wr_value[15:0]}};
            default: wr_lanes = wr_value;
        endcase
    end

    // Pick the addressed lane and right-justify it.
    always_comb begin
        case (rd_size)
            SZ_BYTE: rd_value = {24'd0, lane[rd_off]};
            SZ_HALF: rd_value = rd_off[1] ? {16'd0, rd_word[31:16]}
                                          : {16'd0, rd_word[15:0]};
            default: rd_value = rd_word;
        endcase
    end

endmodule

// File: rtl/dbg_dma_ctrlword.sv
// Control-word builder. Strips the sequencer-owned bits from the
// persistent base and forms the start, poll and final control words.
// Combinational; the base is expected to be held stable by the caller.
module dbg_dma_ctrlword
    import dbg_dma_pkg::*;
(
    input  logic [WORD_W-1:0] base,
    input  logic [1:0]        size,
    input  logic              is_read,
    output logic [WORD_W-1:0] start_word,
    output logic [WORD_W-1:0] poll_word,
    output logic [WORD_W-1:0] final_word
);
    logic [WORD_W-1:0] clean;

    // Base with every owned field cleared.
    assign clean = base & ~OWNED_MASK;

    // Assemble the three words from the cleaned base.
    always_comb begin
        final_word                   = clean;
        poll_word                    = clean;
        poll_word[ACC_BIT]           = 1'b1;
        start_word                   = poll_word;
        start_word[START_BIT]        = 1'b1;
        start_word[SZ_LSB+1:SZ_LSB]  = size;
        start_word[RD_BIT]           = is_read;
    end

endmodule

// File: rtl/dbg_dma_fsm.sv
// Transaction phase machine. Holds the accepted request, walks the scan
// order for each item, polls for completion, checks the error flag,
// retries, steps the burst address and raises the item and done strobes.
// Assumes the scan engine answers each held scan_req with one scan_ack.
module dbg_dma_fsm
    import dbg_dma_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int RETRY_MAX = 2,
    parameter int POLL_MAX  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [WORD_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic [CNT_W-1:0]  req_count,
    input  logic [WORD_W-1:0] base_bits,
    input  logic [WORD_W-1:0] wrep_in,
    input  logic [WORD_W-1:0] rjust_in,
    input  logic [WORD_W-1:0] start_word,
    input  logic [WORD_W-1:0] poll_word,
    input  logic [WORD_W-1:0] final_word,
    output logic [1:0]        size_q,
    output logic              is_read,
    output logic [WORD_W-1:0] base_q,
    output logic [WORD_W-1:0] raw_q,
    output logic [1:0]        off_q,
    output logic              scan_req,
    output logic [1:0]        scan_sel,
    output logic [WORD_W-1:0] scan_dout,
    input  logic              scan_ack,
    input  logic [WORD_W-1:0] scan_din,
    output logic              item_valid,
    output logic [WORD_W-1:0] item_rdata,
    output logic              done,
    output logic [1:0]        done_status,
    output logic [WORD_W-1:0] done_rdata
);
    localparam int PW = (POLL_MAX > 1) ? $clog2(POLL_MAX) : 1;
    localparam int RW = (RETRY_MAX > 0) ? $clog2(RETRY_MAX + 1) : 1;

    phase_e             phase_q;
    logic [WORD_W-1:0]  addr_q;
    logic               wr_q;
    logic [WORD_W-1:0]  wrep_q;
    logic [CNT_W-1:0]   remain_q;
    logic [RW-1:0]      retry_q;
    logic [PW-1:0]      poll_q;
    logic               tmo_q;
    logic               item_valid_q;
    logic [WORD_W-1:0]  item_rdata_q;
    logic               done_q;
    logic [1:0]         done_status_q;
    logic [WORD_W-1:0]  done_rdata_q;
    logic [WORD_W-1:0]  step;
    logic [WORD_W-1:0]  item_value;

    assign size_q      = size_q_r;
    logic [1:0] size_q_r;
    assign is_read     = ~wr_q;
    assign off_q       = addr_q[1:0];
    assign req_ready   = (phase_q == PH_IDLE);
    assign item_valid  = item_valid_q;
    assign item_rdata  = item_rdata_q;
    assign done        = done_q;
    assign done_status = done_status_q;
    assign done_rdata  = done_rdata_q;

    // Address increment of one item.
    assign step = 32'd1 << size_q_r;

    // Value reported for a finished item.
    assign item_value = wr_q ? '0 : rjust_in;

    // Scan port drive, decoded from the current phase.
    always_comb begin
        scan_req  = 1'b1;
        scan_sel  = SEL_CTRL;
        scan_dout = '0;
        case (phase_q)
            PH_ADDR:  begin scan_sel = SEL_ADDR; scan_dout = addr_q;     end
            PH_WDATA: begin scan_sel = SEL_DATA; scan_dout = wrep_q;     end
            PH_START: begin scan_sel = SEL_CTRL; scan_dout = start_word; end
            PH_POLL:  begin scan_sel = SEL_CTRL; scan_dout = poll_word;  end
            PH_RDATA: begin scan_sel = SEL_DATA; scan_dout = '0;         end
            PH_FINAL: begin scan_sel = SEL_CTRL; scan_dout = final_word; end
            default:  begin scan_req = 1'b0; scan_sel = SEL_ADDR;         end
        endcase
    end

    // Phase sequencing, counters and result strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q       <= PH_IDLE;
            addr_q        <= '0;
            size_q_r      <= SZ_WORD;
            wr_q          <= 1'b0;
            wrep_q        <= '0;
            base_q        <= '0;
            raw_q         <= '0;
            remain_q      <= '0;
            retry_q       <= '0;
            poll_q        <= '0;
            tmo_q         <= 1'b0;
            item_valid_q  <= 1'b0;
            item_rdata_q  <= '0;
            done_q        <= 1'b0;
            done_status_q <= ST_OK;
            done_rdata_q  <= '0;
        end else begin
            item_valid_q <= 1'b0;
            done_q       <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (req_valid) begin
                        addr_q   <= req_addr;
                        size_q_r <= req_size;
                        wr_q     <= req_write;
                        wrep_q   <= wrep_in;
                        base_q   <= base_bits;
                        remain_q <= (req_count == '0) ? CNT_W'(1) : req_count;
                        retry_q  <= '0;
                        tmo_q    <= 1'b0;
                        phase_q  <= PH_ADDR;
                    end
                end
                PH_ADDR: begin
                    if (scan_ack) phase_q <= wr_q ? PH_WDATA : PH_START;
                end
                PH_WDATA: begin
                    if (scan_ack) phase_q <= PH_START;
                end
                PH_START: begin
                    if (scan_ack) begin
                        poll_q  <= '0;
                        phase_q <= PH_POLL;
                    end
                end
                PH_POLL: begin
                    if (scan_ack) begin
                        if (!scan_din[START_BIT]) begin
                            phase_q <= wr_q ? PH_FINAL : PH_RDATA;
                        end else if (poll_q == PW'(POLL_MAX - 1)) begin
                            tmo_q   <= 1'b1;
                            phase_q <= PH_FINAL;
                        end else begin
                            poll_q <= poll_q + PW'(1);
                        end
                    end
                end
                PH_RDATA: begin
                    if (scan_ack) begin
                        raw_q   <= scan_din;
                        phase_q <= PH_FINAL;
                    end
                end
                PH_FINAL: begin
                    if (scan_ack) begin
                        if (tmo_q) begin
                            done_q        <= 1'b1;
                            done_status_q <= ST_TIMEOUT;
                            done_rdata_q  <= '0;
                            phase_q       <= PH_IDLE;
                        end else if (scan_din[ERR_BIT]) begin
                            if (int'(retry_q) < RETRY_MAX) begin
                                retry_q <= retry_q + RW'(1);
                                phase_q <= PH_ADDR;
                            end else begin
                                done_q        <= 1'b1;
                                done_status_q <= ST_BUSERR;
                                done_rdata_q  <= '0;
                                phase_q       <= PH_IDLE;
                            end
                        end else begin
                            item_valid_q <= 1'b1;
                            item_rdata_q <= item_value;
                            if (remain_q == CNT_W'(1)) begin
                                done_q        <= 1'b1;
                                done_status_q <= ST_OK;
                                done_rdata_q  <= item_value;
                                phase_q       <= PH_IDLE;
                            end else begin
                                remain_q <= remain_q - CNT_W'(1);
                                addr_q   <= addr_q + step;
                                retry_q  <= '0;
                                phase_q  <= PH_ADDR;
                            end
                        end
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // R1
    scan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_req && !scan_ack) |=> (scan_req && $stable(scan_sel) && $stable(scan_dout)));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !scan_req);

    // R5
    poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_POLL) |-> (int'(poll_q) < POLL_MAX));

    // R6
    retry_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(retry_q) <= RETRY_MAX);

    // R9
    ok_has_item_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && done_status_q == ST_OK) |-> item_valid_q);

    // R5
    done_after_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> $past(scan_ack && scan_sel == SEL_CTRL));

endmodule

// File: rtl/dbg_dma_seq.sv
// Debug DMA transaction sequencer top. Connects the phase machine to the
// control-word builder and the byte-lane unit. The scan engine on the
// other side owns the debug-port state machine; this block only orders
// register scans and interprets their captures.
module dbg_dma_seq
    import dbg_dma_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int RETRY_MAX = 2,
    parameter int POLL_MAX  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [31:0]       req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic [31:0]       req_wdata,
    input  logic [CNT_W-1:0]  req_count,
    input  logic [31:0]       base_bits,
    output logic              scan_req,
    output logic [1:0]        scan_sel,
    output logic [31:0]       scan_dout,
    input  logic              scan_ack,
    input  logic [31:0]       scan_din,
    output logic              item_valid,
    output logic [31:0]       item_rdata,
    output logic              done,
    output logic [1:0]        done_status,
    output logic [31:0]       done_rdata
);
    logic [WORD_W-1:0] wrep;
    logic [WORD_W-1:0] rjust;
    logic [WORD_W-1:0] start_word;
    logic [WORD_W-1:0] poll_word;
    logic [WORD_W-1:0] final_word;
    logic [1:0]        size_q;
    logic              is_read;
    logic [WORD_W-1:0] base_q;
    logic [WORD_W-1:0] raw_q;
    logic [1:0]        off_q;

    dbg_dma_lanes u_lanes (
        .wr_value (req_wdata),
        .wr_size  (req_size),
        .wr_lanes (wrep),
        .rd_word  (raw_q),
        .rd_size  (size_q),
        .rd_off   (off_q),
        .rd_value (rjust)
    );

    dbg_dma_ctrlword u_ctrl (
        .base       (base_q),
        .size       (size_q),
        .is_read    (is_read),
        .start_word (start_word),
        .poll_word  (poll_word),
        .final_word (final_word)
    );

    dbg_dma_fsm #(
        .CNT_W     (CNT_W),
        .RETRY_MAX (RETRY_MAX),
        .POLL_MAX  (POLL_MAX)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_addr    (req_addr),
        .req_size    (req_size),
        .req_write   (req_write),
        .req_count   (req_count),
        .base_bits   (base_bits),
        .wrep_in     (wrep),
        .rjust_in    (rjust),
        .start_word  (start_word),
        .poll_word   (poll_word),
        .final_word  (final_word),
        .size_q      (size_q),
        .is_read     (is_read),
        .base_q      (base_q),
        .raw_q       (raw_q),
        .off_q       (off_q),
        .scan_req    (scan_req),
        .scan_sel    (scan_sel),
        .scan_dout   (scan_dout),
        .scan_ack    (scan_ack),
        .scan_din    (scan_din),
        .item_valid  (item_valid),
        .item_rdata  (item_rdata),
        .done        (done),
        .done_status (done_status),
        .done_rdata  (done_rdata)
    );

endmodule

// File: tb/dbg_dma_seq_tb.sv
// Bench for the debug DMA sequencer: a scan-port device model with a
// small memory, polling latency and error injection, plus a shadow memory
// that carries the expected contents.
module dbg_dma_seq_tb;

    localparam int CNT_W     = 8;
    localparam int RETRY_MAX = 2;
    localparam int POLL_MAX  = 16;
    localparam logic [31:0] OWN_M = 32'h0002_0F80;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [31:0]       req_addr = '0;
    logic [1:0]        req_size = '0;
    logic              req_write = 1'b0;
    logic [31:0]       req_wdata = '0;
    logic [CNT_W-1:0]  req_count = '0;
    logic [31:0]       base_bits = 32'h8002_0A41;
    logic              scan_req;
    logic [1:0]        scan_sel;
    logic [31:0]       scan_dout;
    logic              scan_ack = 1'b0;
    logic [31:0]       scan_din = '0;
    logic              item_valid;
    logic [31:0]       item_rdata;
    logic              done;
    logic [1:0]        done_status;
    logic [31:0]       done_rdata;

    always #4 clk = ~clk;

    dbg_dma_seq #(.CNT_W(CNT_W), .RETRY_MAX(RETRY_MAX), .POLL_MAX(POLL_MAX)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
        .req_wdata(req_wdata), .req_count(req_count), .base_bits(base_bits),
        .scan_req(scan_req), .scan_sel(scan_sel), .scan_dout(scan_dout),
        .scan_ack(scan_ack), .scan_din(scan_din), .item_valid(item_valid),
        .item_rdata(item_rdata), .done(done), .done_status(done_status),
        .done_rdata(done_rdata)
    );

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    // device model state
    logic [31:0] mem    [64];
    logic [31:0] shadow [64];
    logic [31:0] dev_addr = '0;
    logic [31:0] dev_wbuf = '0;
    logic [31:0] dev_rdbuf = '0;
    bit          dev_fail = 0;
    int          dev_busy = 0;
    int          poll_lat = 0;
    int          err_skip = 0;
    int          err_budget = 0;
    int          scan_lat = 0;
    int          lat_cnt = 0;
    logic [1:0]  log_sel [64];
    logic [31:0] log_word [64];
    int          log_n = 0;
    int          n_polls = 0;

    // results
    logic [31:0] items [8];
    int          n_items = 0;
    logic [1:0]  last_status;
    logic [31:0] last_rdata;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] f_rep(input logic [31:0] d, input logic [1:0] sz);
        if (sz == 2'd0) return {4{d[7:0]}};
        if (sz == 2'd1) return {2{d[15:0]}};
        return d;
    endfunction

    function automatic logic [31:0] f_ext(input logic [31:0] w, input logic [1:0] off, input logic [1:0] sz);
        if (sz == 2'd0) return (w >> (8 * off)) & 32'hFF;
        if (sz == 2'd1) return off[1] ? {16'd0, w[31:16]} : {16'd0, w[15:0]};
        return w;
    endfunction

    function automatic logic [31:0] f_merge(input logic [31:0] old, input logic [31:0] d,
                                            input logic [1:0] off, input logic [1:0] sz);
        logic [31:0] r;
        r = old;
        if (sz == 2'd0) r[8*off +: 8] = d[8*off +: 8];
        else if (sz == 2'd1) begin
            if (off[1]) r[31:16] = d[31:16]; else r[15:0] = d[15:0];
        end else r = d;
        return r;
    endfunction

    function automatic logic [31:0] clean_base();
        return base_bits & ~OWN_M;
    endfunction

    // Scan-port device: answers one scan per held request.
    initial begin
        forever begin
            @(negedge clk);
            if (scan_ack) begin
                scan_ack = 1'b0;
                lat_cnt  = 0;
            end else if (scan_req && rst_n) begin
                if (lat_cnt < scan_lat) lat_cnt++;
                else begin
                    if (log_n < 64) begin
                        log_sel[log_n]  = scan_sel;
                        log_word[log_n] = scan_dout;
                        log_n++;
                    end
                    scan_din = '0;
                    if (scan_sel == 2'd0) dev_addr = scan_dout;
                    else if (scan_sel == 2'd1) begin
                        scan_din = dev_rdbuf;
                        dev_wbuf = scan_dout;
                    end else if (scan_dout[11]) begin
                        dev_busy = poll_lat;
                        if (err_skip > 0) begin err_skip--; dev_fail = 0; end
                        else if (err_budget > 0) begin err_budget--; dev_fail = 1; end
                        else dev_fail = 0;
                        if (scan_dout[9])
                            dev_rdbuf = dev_fail ? 32'hDEAD_BEEF : mem[dev_addr[7:2]];
                        else if (!dev_fail)
                            mem[dev_addr[7:2]] = f_merge(mem[dev_addr[7:2]], dev_wbuf,
                                                         dev_addr[1:0], scan_dout[8:7]);
                        scan_din = scan_dout;
                    end else if (scan_dout[17]) begin
                        n_polls++;
                        scan_din = scan_dout;
                        if (dev_busy > 0) begin
                            dev_busy--;
                            scan_din[11] = 1'b1;
                        end
                    end else begin
                        scan_din = scan_dout;
                        scan_din[10] = dev_fail;
                    end
                    scan_ack = 1'b1;
                end
            end
        end
    end

    task automatic run_req(input logic [31:0] a, input logic [1:0] sz, input logic wr,
                           input logic [31:0] wd, input int cnt);
        bit got;
        log_n   = 0;
        n_items = 0;
        n_polls = 0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_addr  = a;
        req_size  = sz;
        req_write = wr;
        req_wdata = wd;
        req_count = CNT_W'(cnt);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        got = 0;
        while (!got) begin
            if (item_valid && n_items < 8) begin
                items[n_items] = item_rdata;
                n_items++;
            end
            if (done) begin
                got = 1;
                last_status = done_status;
                last_rdata  = done_rdata;
            end
            if (!got) @(negedge clk);
        end
    endtask

    // Compare the logged scans of one error-free item with the expected order.
    task automatic check_seq(input string tag, input logic [31:0] a, input logic [1:0] sz,
                             input logic wr, input logic [31:0] wrep, input int polls);
        logic [1:0]  es [64];
        logic [31:0] ew [64];
        bit          wchk [64];
        int          n;
        logic [31:0] sw;
        n  = 0;
        sw = clean_base() | 32'h0002_0800 | ({30'd0, sz} << 7) | (wr ? 32'd0 : 32'h200);
        es[n] = 2'd0; ew[n] = a; wchk[n] = 1; n++;
        if (wr) begin es[n] = 2'd1; ew[n] = wrep; wchk[n] = 1; n++; end
        es[n] = 2'd2; ew[n] = sw; wchk[n] = 1; n++;
        for (int i = 0; i < polls; i++) begin
            es[n] = 2'd2; ew[n] = clean_base() | 32'h0002_0000; wchk[n] = 1; n++;
        end
        if (!wr) begin es[n] = 2'd1; ew[n] = '0; wchk[n] = 0; n++; end
        es[n] = 2'd2; ew[n] = clean_base(); wchk[n] = 1; n++;
        chk({tag, " scan count"}, log_n, n);
        for (int i = 0; i < n && i < log_n; i++) begin
            chk({tag, " scan select"}, {30'd0, log_sel[i]}, {30'd0, es[i]});
            if (wchk[i]) chk({tag, " scan word"}, log_word[i], ew[i]);
        end
    endtask

    function automatic int count_addr_scans();
        int c;
        c = 0;
        for (int i = 0; i < log_n; i++) if (log_sel[i] == 2'd0) c++;
        return c;
    endfunction

    task automatic shadow_write(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] wd);
        shadow[a[7:2]] = f_merge(shadow[a[7:2]], f_rep(wd, sz), a[1:0], sz);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int ad;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 64; i++) begin
            mem[i]    = (32'h0101_0101 * i) ^ 32'hC3A5_5A3C;
            shadow[i] = mem[i];
        end
        mem[12] = 32'h4433_2211;
        shadow[12] = 32'h4433_2211;

        repeat (4) @(negedge clk);
        // R11 reset state
        chk("R11 reset req_ready", {31'd0, req_ready}, 32'd1);
        chk("R11 reset scan_req", {31'd0, scan_req}, 32'd0);
        chk("R11 reset done", {31'd0, done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R4 single word write with two busy polls
        poll_lat = 2;
        run_req(32'h10, 2'd2, 1'b1, 32'h1122_3344, 1);
        shadow_write(32'h10, 2'd2, 32'h1122_3344);
        check_seq("R2 R3 R4 word write", 32'h10, 2'd2, 1'b1, 32'h1122_3344, 3);
        chk("R2 status", {30'd0, last_status}, 32'd0);
        chk("R2 memory", mem[4], 32'h1122_3344);

        // R1 R3 R7 single word read
        scan_lat = 2;
        poll_lat = 0;
        run_req(32'h10, 2'd2, 1'b0, 32'h0, 1);
        check_seq("R1 R3 word read", 32'h10, 2'd2, 1'b0, 32'h0, 1);
        chk("R7 word read data", last_rdata, 32'h1122_3344);
        chk("R9 single item strobe", n_items, 1);
        scan_lat = 0;

        // R8 byte write lane 1
        run_req(32'h21, 2'd0, 1'b1, 32'h0000_00A5, 1);
        shadow_write(32'h21, 2'd0, 32'hA5);
        check_seq("R8 byte write", 32'h21, 2'd0, 1'b1, 32'hA5A5_A5A5, 1);
        chk("R8 byte lane in memory", mem[8], shadow[8]);

        // R8 halfword write upper half
        poll_lat = 1;
        run_req(32'h26, 2'd1, 1'b1, 32'h0000_BEEF, 1);
        shadow_write(32'h26, 2'd1, 32'hBEEF);
        check_seq("R8 half write", 32'h26, 2'd1, 1'b1, 32'hBEEF_BEEF, 2);
        chk("R8 half lane in memory", mem[9], shadow[9]);
        poll_lat = 0;

        // R7 every byte lane and both halves
        for (int k = 0; k < 4; k++) begin
            run_req(32'h30 + k, 2'd0, 1'b0, 32'h0, 1);
            chk("R7 byte lane read", last_rdata, 32'h11 * (k + 1));
        end
        run_req(32'h30, 2'd1, 1'b0, 32'h0, 1);
        check_seq("R3 half read", 32'h30, 2'd1, 1'b0, 32'h0, 1);
        chk("R7 low half read", last_rdata, 32'h2211);
        run_req(32'h32, 2'd1, 1'b0, 32'h0, 1);
        chk("R7 high half read", last_rdata, 32'h4433);

        // R6 two failures then success
        err_budget = 2;
        run_req(32'h30, 2'd2, 1'b0, 32'h0, 1);
        chk("R6 recovered status", {30'd0, last_status}, 32'd0);
        chk("R6 restarts from address", count_addr_scans(), 3);
        chk("R6 recovered data", last_rdata, 32'h4433_2211);

        // R6 retries exhausted
        err_budget = 3;
        run_req(32'h30, 2'd2, 1'b0, 32'h0, 1);
        chk("R6 bus error status", {30'd0, last_status}, 32'd1);
        chk("R6 attempts", count_addr_scans(), RETRY_MAX + 1);
        chk("R6 no item on failure", n_items, 0);
        err_budget = 0;

        // R5 timeout
        poll_lat = 1000;
        run_req(32'h14, 2'd2, 1'b1, 32'h5555_AAAA, 1);
        chk("R5 timeout status", {30'd0, last_status}, 32'd2);
        chk("R5 poll count", n_polls, POLL_MAX);
        chk("R5 single attempt", count_addr_scans(), 1);
        chk("R5 final scan word", log_word[log_n-1], clean_base());
        poll_lat = 0;
        // memory write occurred at start of the op in the device model
        shadow_write(32'h14, 2'd2, 32'h5555_AAAA);

        // R9 halfword write burst with address stepping
        run_req(32'h40, 2'd1, 1'b1, 32'h0000_1234, 4);
        chk("R9 burst status", {30'd0, last_status}, 32'd0);
        chk("R9 burst items", n_items, 4);
        begin
            int j;
            j = 0;
            for (int i = 0; i < log_n; i++)
                if (log_sel[i] == 2'd0) begin
                    chk("R9 burst address step", log_word[i], 32'h40 + 2 * j);
                    j++;
                end
        end
        for (int k = 0; k < 4; k++) shadow_write(32'h40 + 2 * k, 2'd1, 32'h1234);
        chk("R9 burst memory 0", mem[16], 32'h1234_1234);
        chk("R9 burst memory 1", mem[17], 32'h1234_1234);

        // R9 byte read burst
        run_req(32'h30, 2'd0, 1'b0, 32'h0, 4);
        chk("R9 byte burst items", n_items, 4);
        for (int k = 0; k < 4; k++) chk("R9 byte burst data", items[k], 32'h11 * (k + 1));

        // R9 count zero acts as one
        run_req(32'h30, 2'd2, 1'b0, 32'h0, 0);
        chk("R9 count zero items", n_items, 1);
        chk("R9 count zero addr scans", count_addr_scans(), 1);

        // R10 burst abort on the second item
        err_skip = 1;
        err_budget = 3;
        run_req(32'h00, 2'd2, 1'b0, 32'h0, 4);
        chk("R10 abort status", {30'd0, last_status}, 32'd1);
        chk("R10 abort items", n_items, 1);
        chk("R10 abort addr scans", count_addr_scans(), 1 + RETRY_MAX + 1);
        chk("R10 last addr", log_word[log_n - 1 - 4], 32'h04);
        err_skip = 0;
        err_budget = 0;

        // R7 R8 R9 random traffic against the shadow memory
        for (int t = 0; t < 40; t++) begin
            logic [1:0]  sz;
            logic        wr;
            logic [31:0] a;
            logic [31:0] wd;
            int          cnt;
            sz  = 2'($urandom_range(0, 2));
            wr  = 1'($urandom_range(0, 1));
            cnt = $urandom_range(1, 4);
            wd  = $urandom;
            ad  = $urandom_range(0, 50) * 4;
            if (sz == 2'd0) ad = ad + $urandom_range(0, 3);
            else if (sz == 2'd1) ad = ad + 2 * $urandom_range(0, 1);
            a = ad;
            poll_lat = $urandom_range(0, 3);
            scan_lat = $urandom_range(0, 2);
            run_req(a, sz, wr, wd, cnt);
            chk("R9 random status", {30'd0, last_status}, 32'd0);
            chk("R9 random item count", n_items, cnt);
            for (int k = 0; k < cnt; k++) begin
                logic [31:0] ia;
                ia = a + (k << sz);
                if (wr) shadow_write(ia, sz, wd);
                else if (k < n_items)
                    chk("R7 random read data", items[k], f_ext(shadow[ia[7:2]], ia[1:0], sz));
            end
        end
        for (int i = 0; i < 64; i++) chk("R8 memory image", mem[i], shadow[i]);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule